// File: doc/BRIEF.md
# Error-Correcting Two-Port Memory with Write Arbitration

This block is a two-port synchronous RAM in which every word is stored together with a single-error-correcting, double-error-detecting Hamming code. Storage is split into two banks: even addresses in one, odd addresses in the other, chosen by address bit 0. Each port has its own address, write data, write enable and read enable. Each port returns the read data one clock after the request, together with a flag for a corrected error and a flag for an uncorrectable error.

When both ports write the same address in the same cycle, a two-way round-robin arbiter lets one of them through and holds the other back for a cycle. When a read finds and fixes a single-bit error, the repaired codeword goes back into the same location on the following clock. That write takes priority over any port write to the same bank. A test-only input flips one or two chosen bits of a chosen stored word, so that the correction and detection paths can be exercised.

Top module: `secded_dpram`

## Requirements
- R1: A word written through either port is returned unchanged by a later read from either port. Read data and its flags appear one clock after the request cycle, and `*_rvalid` is high only in that cycle.
- R2: The stored word holds `DATA_W + CHK_W + 1` bits, which is 22 bits for 16-bit data. Flipping any single stored bit, at any index 0..21, still returns the written data, with `*_corr` high and `*_uncorr` low.
- R3: Flipping any two distinct stored bits of a word gives `*_uncorr` high and `*_corr` low on a read of it.
- R4: After a read reports a corrected error, the repaired word is written back on the next clock. A read issued after that write-back cycle returns the data with both flags low.
- R5: A word with an uncorrectable error is never written back. Every later read of it reports `*_uncorr` again, until a port writes the word anew.
- R6: When both ports write the same address in the same cycle, exactly one `*_rdy` stays high. The first such conflict after reset goes to port A. The held port completes its write in the next cycle, so its data is what remains.
- R7: Write priority swaps after every same-address conflict and does not move in cycles without a conflict. Conflicts therefore go A, B, A, even when plain writes lie between them.
- R8: Writes from the two ports to different banks, or to different addresses in one bank, are both accepted in the same cycle with both `*_rdy` high.
- R9: In the cycle of a write-back to a bank, a port write to that bank sees `*_rdy` low and is taken on the following cycle. A port write to the other bank in that cycle is accepted.
- R10: A read and a write to the same address in the same cycle return the previously stored data, whether both come from one port or one from each port.
- R11: After reset, both `*_rdy` are high, both `*_rvalid` are low, and every word reads as zero with both flags low.
- R12: A fault-injection index at or above the stored word width flips nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_addr | input | AW | Port A word address; bit 0 selects the bank |
| a_wdata | input | DATA_W | Port A write data |
| a_we | input | 1 | Port A write request, held until `a_rdy` is high |
| a_re | input | 1 | Port A read request |
| a_rdy | output | 1 | Port A write taken this cycle (high when no write is requested) |
| a_rdata | output | DATA_W | Port A read data, after correction |
| a_rvalid | output | 1 | Port A read result present |
| a_corr | output | 1 | Port A read had a single-bit error that was fixed |
| a_uncorr | output | 1 | Port A read had an uncorrectable error |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_we | input | 1 | Port B write request |
| b_re | input | 1 | Port B read request |
| b_rdy | output | 1 | Port B write taken this cycle |
| b_rdata | output | DATA_W | Port B read data, after correction |
| b_rvalid | output | 1 | Port B read result present |
| b_corr | output | 1 | Port B corrected-error flag |
| b_uncorr | output | 1 | Port B uncorrectable-error flag |
| fi_en | input | 1 | Apply a fault to a stored word this cycle |
| fi_addr | input | AW | Address of the word to corrupt |
| fi_pos0 | input | PW | Index of the first bit to flip |
| fi_pos1 | input | PW | Index of the second bit to flip |
| fi_two | input | 1 | Also flip the bit at `fi_pos1` |

## Verification
The bench builds the block with its default parameters: 16-bit data and 64 words. That gives 22-bit codewords with five position checks and one overall parity bit, and 32 rows per bank.

With these values the bench can reach every stored bit index, so single flips cover the overall parity bit, each check bit and every data position. Double flips cover pairs that mix those classes. A fault index beyond the word is also reachable with a 5-bit index.

All 64 addresses are written and read back across both banks. The bench also drives same-address conflicts in three successive rounds, and a write-back collision in both the blocked bank and the free one.

// File: rtl/secded_dpram_pkg.sv
package secded_dpram_pkg;

    // Which port wins the next same-address write conflict
    typedef enum logic {
        PRI_A = 1'b0,
        PRI_B = 1'b1
    } pri_e;

    // Smallest number of Hamming position checks able to cover dw data bits
    function automatic int chk_bits(input int dw);
        int res;
        res = 0;
        for (int r = 31; r >= 1; r--) begin
            if ((1 << r) >= dw + r + 1) res = r;
        end
        return res;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder #(
    parameter  int DATA_W = 16,
    localparam int CHK_W  = secded_dpram_pkg::chk_bits(DATA_W),
    localparam int HAM_N  = DATA_W + CHK_W,
    localparam int CW_W   = HAM_N + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);

    logic [CW_W-1:0] w;

    // Bit 0: overall parity. Bits 1..HAM_N: Hamming positions.
    // Check bits sit at the power-of-two positions.
    always_comb begin
        int  k;
        logic p;
        w = '0;
        k = 0;
        for (int pos = 1; pos <= HAM_N; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                w[pos] = data_i[k];
                k = k + 1;
            end
        end
        for (int i = 0; i < CHK_W; i++) begin
            p = 1'b0;
            for (int pos = 1; pos <= HAM_N; pos++) begin
                if (((pos >> i) & 1) == 1) p = p ^ w[pos];
            end
            w[1 << i] = p;
        end
        w[0] = ^w[CW_W-1:1];
    end

    assign cw_o = w;

endmodule

// File: rtl/secded_decoder.sv
module secded_decoder #(
    parameter  int DATA_W = 16,
    localparam int CHK_W  = secded_dpram_pkg::chk_bits(DATA_W),
    localparam int HAM_N  = DATA_W + CHK_W,
    localparam int CW_W   = HAM_N + 1
) (
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CW_W-1:0]   fixed_o,
    output logic              corr_o,
    output logic              uncorr_o
);

    logic [CHK_W-1:0] syn;
    logic             par;
    logic             hit;

    always_comb begin
        int k;
        syn = '0;
        for (int i = 0; i < CHK_W; i++) begin
            for (int pos = 1; pos <= HAM_N; pos++) begin
                if (((pos >> i) & 1) == 1) syn[i] = syn[i] ^ cw_i[pos];
            end
        end
        par      = ^cw_i;
        fixed_o  = cw_i;
        corr_o   = 1'b0;
        uncorr_o = 1'b0;
        hit      = 1'b0;
        if (par) begin
            if (syn == '0) begin
                // only the overall parity bit itself is wrong
                fixed_o[0] = ~cw_i[0];
                corr_o     = 1'b1;
            end else begin
                for (int pos = 1; pos <= HAM_N; pos++) begin
                    if (int'(syn) == pos) begin
                        fixed_o[pos] = ~cw_i[pos];
                        hit          = 1'b1;
                    end
                end
                corr_o   = hit;
                uncorr_o = ~hit;
            end
        end else if (syn != '0) begin
            uncorr_o = 1'b1;
        end
        data_o = '0;
        k = 0;
        for (int pos = 1; pos <= HAM_N; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                data_o[k] = fixed_o[pos];
                k = k + 1;
            end
        end
    end

endmodule

// File: rtl/secded_bank.sv
module secded_bank #(
    parameter  int CW_W = 22,
    parameter  int ROWS = 32,
    localparam int RW   = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wa_en,
    input  logic [RW-1:0]   wa_row,
    input  logic [CW_W-1:0] wa_cw,
    input  logic            wb_en,
    input  logic [RW-1:0]   wb_row,
    input  logic [CW_W-1:0] wb_cw,
    input  logic            fi_en,
    input  logic [RW-1:0]   fi_row,
    input  logic [CW_W-1:0] fi_mask,
    input  logic [RW-1:0]   ra_row,
    output logic [CW_W-1:0] ra_cw,
    input  logic [RW-1:0]   rb_row,
    output logic [CW_W-1:0] rb_cw
);

    logic [CW_W-1:0] mem_q [ROWS];
    logic [CW_W-1:0] mem_d [ROWS];

    always_comb begin
        mem_d = mem_q;
        if (wb_en) mem_d[wb_row] = wb_cw;
        if (wa_en) mem_d[wa_row] = wa_cw;
        if (fi_en) mem_d[fi_row] = mem_d[fi_row] ^ fi_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign ra_cw = mem_q[ra_row];
    assign rb_cw = mem_q[rb_row];

    // R6
    same_row_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en && wa_row == wb_row) |-> (wa_cw == wb_cw));

endmodule

// File: rtl/secded_dpram.sv
module secded_dpram
    import secded_dpram_pkg::*;
#(
    parameter  int DATA_W = 16,
    parameter  int DEPTH  = 64,
    localparam int CHK_W  = secded_dpram_pkg::chk_bits(DATA_W),
    localparam int CW_W   = DATA_W + CHK_W + 1,
    localparam int AW     = $clog2(DEPTH),
    localparam int ROWS   = DEPTH / 2,
    localparam int RW     = AW - 1,
    localparam int PW     = $clog2(CW_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_we,
    input  logic              a_re,
    output logic              a_rdy,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rvalid,
    output logic              a_corr,
    output logic              a_uncorr,
    input  logic [AW-1:0]     b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_we,
    input  logic              b_re,
    output logic              b_rdy,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rvalid,
    output logic              b_corr,
    output logic              b_uncorr,
    input  logic              fi_en,
    input  logic [AW-1:0]     fi_addr,
    input  logic [PW-1:0]     fi_pos0,
    input  logic [PW-1:0]     fi_pos1,
    input  logic              fi_two
);

    typedef struct packed {
        logic            vld;
        logic [AW-1:0]   addr;
        logic [CW_W-1:0] cw;
        logic            clob;   // location rewritten in the read cycle
    } rd_stage_t;

    typedef struct packed {
        pri_e               pri;
        rd_stage_t [1:0]    rd;
    } state_t;

    state_t st_q, st_d;

    // Port-indexed views: 0 = A, 1 = B
    logic [1:0]        we, re, rdy;
    logic [AW-1:0]     addr   [2];
    logic [DATA_W-1:0] wdata  [2];
    logic [CW_W-1:0]   enc    [2];
    logic [CW_W-1:0]   dfix   [2];
    logic [DATA_W-1:0] ddata  [2];
    logic [1:0]        dcorr, dunc;
    logic [1:0]        scrub, sbank, busy, req, go, clob_v;
    logic [RW-1:0]     srow   [2];
    logic              conflict;

    // Bank-side signals: [bank][port slot]
    logic [CW_W-1:0]   brd    [2][2];
    logic              bw_en  [2][2];
    logic [RW-1:0]     bw_row [2][2];
    logic [CW_W-1:0]   bw_cw  [2][2];
    logic [1:0]        fen;
    logic [CW_W-1:0]   fmask;

    assign we       = {b_we, a_we};
    assign re       = {b_re, a_re};
    assign addr[0]  = a_addr;
    assign addr[1]  = b_addr;
    assign wdata[0] = a_wdata;
    assign wdata[1] = b_wdata;

    for (genvar p = 0; p < 2; p++) begin : g_port
        secded_encoder #(.DATA_W(DATA_W)) u_enc (
            .data_i (wdata[p]),
            .cw_o   (enc[p])
        );
        secded_decoder #(.DATA_W(DATA_W)) u_dec (
            .cw_i     (st_q.rd[p].cw),
            .data_o   (ddata[p]),
            .fixed_o  (dfix[p]),
            .corr_o   (dcorr[p]),
            .uncorr_o (dunc[p])
        );
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        secded_bank #(.CW_W(CW_W), .ROWS(ROWS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wa_en   (bw_en[b][0]),
            .wa_row  (bw_row[b][0]),
            .wa_cw   (bw_cw[b][0]),
            .wb_en   (bw_en[b][1]),
            .wb_row  (bw_row[b][1]),
            .wb_cw   (bw_cw[b][1]),
            .fi_en   (fen[b]),
            .fi_row  (fi_addr[AW-1:1]),
            .fi_mask (fmask),
            .ra_row  (a_addr[AW-1:1]),
            .ra_cw   (brd[b][0]),
            .rb_row  (b_addr[AW-1:1]),
            .rb_cw   (brd[b][1])
        );
    end

    always_comb begin
        st_d = st_q;

        // write-back of a repaired word, one clock after its read
        for (int p = 0; p < 2; p++) begin
            sbank[p] = st_q.rd[p].addr[0];
            srow[p]  = st_q.rd[p].addr[AW-1:1];
            scrub[p] = st_q.rd[p].vld && dcorr[p] && !st_q.rd[p].clob;
        end
        for (int b = 0; b < 2; b++) begin
            busy[b] = (scrub[0] && sbank[0] == b[0]) || (scrub[1] && sbank[1] == b[0]);
        end

        // port writes, then same-address arbitration
        for (int p = 0; p < 2; p++) begin
            req[p] = we[p] && !busy[addr[p][0]];
        end
        conflict = req[0] && req[1] && (addr[0] == addr[1]);
        go[0]    = req[0] && !(conflict && st_q.pri == PRI_B);
        go[1]    = req[1] && !(conflict && st_q.pri == PRI_A);
        for (int p = 0; p < 2; p++) rdy[p] = !we[p] || go[p];
        if (conflict) st_d.pri = (st_q.pri == PRI_A) ? PRI_B : PRI_A;

        // bank write slots: the write-back owns the slot when present
        for (int b = 0; b < 2; b++) begin
            for (int p = 0; p < 2; p++) begin
                bw_en[b][p]  = 1'b0;
                bw_row[b][p] = '0;
                bw_cw[b][p]  = '0;
                if (scrub[p] && sbank[p] == b[0]) begin
                    bw_en[b][p]  = 1'b1;
                    bw_row[b][p] = srow[p];
                    bw_cw[b][p]  = dfix[p];
                end else if (go[p] && addr[p][0] == b[0]) begin
                    bw_en[b][p]  = 1'b1;
                    bw_row[b][p] = addr[p][AW-1:1];
                    bw_cw[b][p]  = enc[p];
                end
            end
        end

        // fault injection
        for (int i = 0; i < CW_W; i++) begin
            fmask[i] = (int'(fi_pos0) == i) || (fi_two && int'(fi_pos1) == i);
        end
        for (int b = 0; b < 2; b++) fen[b] = fi_en && (fi_addr[0] == b[0]);

        // read capture (old contents: read-first)
        for (int p = 0; p < 2; p++) begin
            clob_v[p] = 1'b0;
            for (int q = 0; q < 2; q++) begin
                if (go[q] && addr[q] == addr[p]) clob_v[p] = 1'b1;
                if (scrub[q] && st_q.rd[q].addr == addr[p]) clob_v[p] = 1'b1;
            end
            st_d.rd[p].vld  = re[p];
            st_d.rd[p].addr = addr[p];
            st_d.rd[p].cw   = addr[p][0] ? brd[1][p] : brd[0][p];
            st_d.rd[p].clob = clob_v[p] && re[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pri: PRI_A, rd: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign a_rdy    = rdy[0];
    assign b_rdy    = rdy[1];
    assign a_rdata  = ddata[0];
    assign b_rdata  = ddata[1];
    assign a_rvalid = st_q.rd[0].vld;
    assign b_rvalid = st_q.rd[1].vld;
    assign a_corr   = st_q.rd[0].vld && dcorr[0];
    assign b_corr   = st_q.rd[1].vld && dcorr[1];
    assign a_uncorr = st_q.rd[0].vld && dunc[0];
    assign b_uncorr = st_q.rd[1].vld && dunc[1];

    // R1
    a_rvalid_follows_re_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_rvalid |-> $past(a_re));

    // R1
    b_rvalid_follows_re_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_rvalid |-> $past(b_re));

    // R3
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_corr && a_uncorr) && !(b_corr && b_uncorr));

    // R6
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && b_we && a_addr == b_addr) |-> !(a_rdy && b_rdy));

    // R7
    pri_moves_on_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pri != $past(st_q.pri)) |-> $past(conflict));

    // R9
    scrub_blocks_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_corr && !st_q.rd[0].clob && b_we && b_addr[0] == st_q.rd[0].addr[0]) |-> !b_rdy);

endmodule

// File: tb/secded_dpram_tb.sv
module secded_dpram_tb;

    localparam int DW = 16;
    localparam int AW = 6;
    localparam int PW = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [AW-1:0] a_addr, b_addr, fi_addr;
    logic [DW-1:0] a_wdata, b_wdata;
    logic          a_we, a_re, b_we, b_re, fi_en, fi_two;
    logic [PW-1:0] fi_pos0, fi_pos1;
    logic          a_rdy, a_rvalid, a_corr, a_uncorr;
    logic          b_rdy, b_rvalid, b_corr, b_uncorr;
    logic [DW-1:0] a_rdata, b_rdata;

    secded_dpram u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_re(a_re), .a_rdy(a_rdy),
        .a_rdata(a_rdata), .a_rvalid(a_rvalid), .a_corr(a_corr), .a_uncorr(a_uncorr),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_re(b_re), .b_rdy(b_rdy),
        .b_rdata(b_rdata), .b_rvalid(b_rvalid), .b_corr(b_corr), .b_uncorr(b_uncorr),
        .fi_en(fi_en), .fi_addr(fi_addr), .fi_pos0(fi_pos0), .fi_pos1(fi_pos1), .fi_two(fi_two)
    );

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic [DW-1:0] data;
        logic          corr;
        logic          uncorr;
        bit            use_data;
        string         req;
    } exp_t;

    exp_t qa[$];
    exp_t qb[$];
    exp_t ea, eb;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic judge(input exp_t e, input string port, input logic [DW-1:0] d, input logic c, input logic u);
        chk(e.req, {port, " corrected flag"}, 32'(c), 32'(e.corr));
        chk(e.req, {port, " uncorrectable flag"}, 32'(u), 32'(e.uncorr));
        if (e.use_data) chk(e.req, {port, " read data"}, 32'(d), 32'(e.data));
    endtask

    // monitor: retire one expected item per valid read result
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (a_rvalid === 1'b1) begin
                if (qa.size() == 0) chk("R1", "port A unexpected result", 32'd1, 32'd0);
                else begin ea = qa.pop_front(); judge(ea, "port A", a_rdata, a_corr, a_uncorr); end
            end
            if (b_rvalid === 1'b1) begin
                if (qb.size() == 0) chk("R1", "port B unexpected result", 32'd1, 32'd0);
                else begin eb = qb.pop_front(); judge(eb, "port B", b_rdata, b_corr, b_uncorr); end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic exp_t mk(input logic [DW-1:0] d, input logic c, input logic u, input bit ud, input string req);
        exp_t e;
        e.data = d; e.corr = c; e.uncorr = u; e.use_data = ud; e.req = req;
        return e;
    endfunction

    task automatic rd(input bit pb, input logic [AW-1:0] ad, input logic [DW-1:0] d,
                      input logic c, input logic u, input bit ud, input string req);
        if (!pb) begin a_addr = ad; a_re = 1'b1; qa.push_back(mk(d, c, u, ud, req)); end
        else     begin b_addr = ad; b_re = 1'b1; qb.push_back(mk(d, c, u, ud, req)); end
        tick();
        a_re = 1'b0;
        b_re = 1'b0;
    endtask

    task automatic wr(input bit pb, input logic [AW-1:0] ad, input logic [DW-1:0] d, input string req);
        if (!pb) begin a_addr = ad; a_wdata = d; a_we = 1'b1; end
        else     begin b_addr = ad; b_wdata = d; b_we = 1'b1; end
        #1;
        chk(req, "write ready", 32'(pb ? b_rdy : a_rdy), 32'd1);
        tick();
        a_we = 1'b0;
        b_we = 1'b0;
    endtask

    task automatic inject(input logic [AW-1:0] ad, input int p0, input int p1, input logic two);
        fi_addr = ad; fi_pos0 = PW'(p0); fi_pos1 = PW'(p1); fi_two = two; fi_en = 1'b1;
        tick();
        fi_en = 1'b0; fi_two = 1'b0;
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 16'h0101) ^ 16'h5A3C;
    endfunction

    localparam logic [DW-1:0] DV = 16'hC3A5;

    initial begin
        rst_n = 1'b0;
        a_addr = '0; b_addr = '0; fi_addr = '0;
        a_wdata = '0; b_wdata = '0;
        a_we = 0; a_re = 0; b_we = 0; b_re = 0;
        fi_en = 0; fi_two = 0; fi_pos0 = '0; fi_pos1 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R11 reset state
        chk("R11", "A ready after reset", 32'(a_rdy), 32'd1);
        chk("R11", "B ready after reset", 32'(b_rdy), 32'd1);
        chk("R11", "A rvalid after reset", 32'(a_rvalid), 32'd0);
        chk("R11", "B rvalid after reset", 32'(b_rvalid), 32'd0);
        @(negedge clk);
        rd(1'b0, 6'd0, 16'h0, 0, 0, 1, "R11");
        rd(1'b1, 6'd63, 16'h0, 0, 0, 1, "R11");

        // R1 every address, written on one port, read on the other
        for (int a = 0; a < 64; a++) wr(a[0], AW'(a), pat(a), "R1");
        for (int a = 0; a < 64; a++) rd(!a[0], AW'(a), pat(a), 0, 0, 1, "R1");

        // R8 different banks, then same bank different rows
        a_addr = 6'd20; a_wdata = 16'h1111; a_we = 1;
        b_addr = 6'd21; b_wdata = 16'h2222; b_we = 1;
        #1;
        chk("R8", "A ready, split banks", 32'(a_rdy), 32'd1);
        chk("R8", "B ready, split banks", 32'(b_rdy), 32'd1);
        tick();
        a_addr = 6'd22; a_wdata = 16'h3333;
        b_addr = 6'd24; b_wdata = 16'h4444;
        #1;
        chk("R8", "A ready, same bank", 32'(a_rdy), 32'd1);
        chk("R8", "B ready, same bank", 32'(b_rdy), 32'd1);
        tick();
        a_we = 0; b_we = 0;
        rd(1'b0, 6'd20, 16'h1111, 0, 0, 1, "R8");
        rd(1'b0, 6'd21, 16'h2222, 0, 0, 1, "R8");
        rd(1'b1, 6'd22, 16'h3333, 0, 0, 1, "R8");
        rd(1'b1, 6'd24, 16'h4444, 0, 0, 1, "R8");

        // R6 first conflict: A wins, B completes next cycle
        a_addr = 6'd10; a_wdata = 16'hAAAA; a_we = 1;
        b_addr = 6'd10; b_wdata = 16'hBBBB; b_we = 1;
        #1;
        chk("R6", "A ready on first conflict", 32'(a_rdy), 32'd1);
        chk("R6", "B ready on first conflict", 32'(b_rdy), 32'd0);
        tick();
        a_we = 0;
        #1;
        chk("R6", "B ready on retry", 32'(b_rdy), 32'd1);
        tick();
        b_we = 0;
        rd(1'b0, 6'd10, 16'hBBBB, 0, 0, 1, "R6");

        // R7 plain writes between conflicts do not move priority
        wr(1'b0, 6'd40, 16'h0404, "R7");
        wr(1'b1, 6'd41, 16'h0505, "R7");
        a_addr = 6'd12; a_wdata = 16'h1212; a_we = 1;
        b_addr = 6'd12; b_wdata = 16'h3434; b_we = 1;
        #1;
        chk("R7", "A ready on second conflict", 32'(a_rdy), 32'd0);
        chk("R7", "B ready on second conflict", 32'(b_rdy), 32'd1);
        tick();
        b_we = 0;
        #1;
        chk("R7", "A ready on retry", 32'(a_rdy), 32'd1);
        tick();
        a_we = 0;
        rd(1'b1, 6'd12, 16'h1212, 0, 0, 1, "R7");
        a_addr = 6'd15; a_wdata = 16'h5656; a_we = 1;
        b_addr = 6'd15; b_wdata = 16'h7878; b_we = 1;
        #1;
        chk("R7", "A ready on third conflict", 32'(a_rdy), 32'd1);
        chk("R7", "B ready on third conflict", 32'(b_rdy), 32'd0);
        tick();
        a_we = 0;
        tick();
        b_we = 0;
        rd(1'b0, 6'd15, 16'h7878, 0, 0, 1, "R7");

        // R10 read-first, same port then across ports
        wr(1'b0, 6'd30, 16'hAAAA, "R10");
        a_addr = 6'd30; a_wdata = 16'hBBBB; a_we = 1; a_re = 1;
        qa.push_back(mk(16'hAAAA, 0, 0, 1, "R10"));
        tick();
        a_we = 0; a_re = 0;
        rd(1'b0, 6'd30, 16'hBBBB, 0, 0, 1, "R10");
        a_addr = 6'd30; a_wdata = 16'hCCCC; a_we = 1;
        b_addr = 6'd30; b_re = 1;
        qb.push_back(mk(16'hBBBB, 0, 0, 1, "R10"));
        tick();
        a_we = 0; b_re = 0;
        rd(1'b1, 6'd30, 16'hCCCC, 0, 0, 1, "R10");

        // R2 / R4 every single-bit position, then the repaired word reads clean
        wr(1'b0, 6'd6, DV, "R2");
        for (int k = 0; k < 22; k++) begin
            inject(6'd6, k, 0, 1'b0);
            rd(k[0], 6'd6, DV, 1, 0, 1, "R2");
            tick();
            rd(!k[0], 6'd6, DV, 0, 0, 1, "R4");
        end

        // R12 index beyond the stored word
        inject(6'd6, 25, 0, 1'b0);
        rd(1'b0, 6'd6, DV, 0, 0, 1, "R12");

        // R3 / R5 double flips stay uncorrectable until rewritten
        for (int k = 0; k < 22; k++) begin
            inject(6'd6, k, (k + 7) % 22, 1'b1);
            rd(1'b0, 6'd6, DV, 0, 1, 0, "R3");
            tick();
            rd(1'b1, 6'd6, DV, 0, 1, 0, "R5");
            wr(1'b0, 6'd6, DV, "R5");
            rd(1'b0, 6'd6, DV, 0, 0, 1, "R5");
        end

        // R9 write-back blocks a port write to its bank for one cycle
        wr(1'b0, 6'd4, 16'h1234, "R9");
        wr(1'b1, 6'd8, 16'h0000, "R9");
        inject(6'd4, 7, 0, 1'b0);
        a_addr = 6'd4; a_re = 1;
        qa.push_back(mk(16'h1234, 1, 0, 1, "R9"));
        tick();
        a_re = 0;
        b_addr = 6'd8; b_wdata = 16'h5A5A; b_we = 1;
        a_addr = 6'd5; a_wdata = 16'h0F0F; a_we = 1;
        #1;
        chk("R9", "B ready during write-back", 32'(b_rdy), 32'd0);
        chk("R9", "A ready, other bank", 32'(a_rdy), 32'd1);
        tick();
        a_we = 0;
        #1;
        chk("R9", "B ready after write-back", 32'(b_rdy), 32'd1);
        tick();
        b_we = 0;
        rd(1'b0, 6'd8, 16'h5A5A, 0, 0, 1, "R9");
        rd(1'b1, 6'd5, 16'h0F0F, 0, 0, 1, "R9");
        rd(1'b0, 6'd4, 16'h1234, 0, 0, 1, "R4");

        tick();
        tick();
        chk("R1", "port A results outstanding", 32'(qa.size()), 32'd0);
        chk("R1", "port B results outstanding", 32'(qb.size()), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule